// File: doc/BRIEF.md
# Dual-Rail Precharged S-Box Test Datapath

This block is a small test datapath for judging a partially protected, dual-rail logic style. A single-ended 8-bit linear feedback shift register produces a byte. The byte passes through the AES S-box, is combined by XOR with a key byte, and lands in a first register. A second register then hands the result to the outputs as an ordinary single-ended byte. Only the S-box, the key XOR and the first register are protected. The shift register and the output register stay single-ended to save area.

Inside the protected section every bit travels as a true rail and a false rail. Both rails sit at 0 during precharge. During evaluation exactly one rail of each bit rises, so the same number of wires switch whatever the data is. The block runs on a two-clock word cycle: a precharge clock followed by an evaluate clock. The S-box is built only from monotonic AND/OR structure, as a one-hot minterm decoder followed by rail-selective OR trees. A registered rail-error flag reports any evaluated bit whose two rails agree.

Top module: `dpa_sbox_path`

## Requirements
- R1: While rst_n is low, q_o and rail_err_o are 0.
- R2: On the first clock after reset release the shift register loads seed_i. A seed of 0x00 is replaced by 0x01. The first evaluated word uses this loaded value.
- R3: The shift register advances once per word cycle (every second clock), as new = {s[6:0], s[7]^s[5]^s[4]^s[3]}. This is the polynomial x^8+x^6+x^5+x^4+1, and it visits all 255 nonzero states.
- R4: Each word's result is the AES S-box of the shift register value, XORed with key_i (key sampled in the evaluate clock).
- R5: Counting clock edges after reset release from 1, word n (n = 0, 1, ...) appears on q_o after edge 2n+3 and holds through edge 2n+4.
- R6: During the precharge clock both rails of every protected signal are 0.
- R7: During the evaluate clock exactly one rail of each S-box output bit is 1, and exactly one decoder minterm is active.
- R8: The first register captures the dual-rail XOR result at the end of the evaluate clock. Its rails are cleared at the end of the following precharge clock, so they read 0 during every evaluate clock. The output register takes the true rail.
- R9: rail_err_o rises one clock after an evaluated or held protected bit has equal rails. With a correct datapath it stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| key_i | input | 8 | Key byte XORed onto the S-box output |
| seed_i | input | 8 | Starting value for the shift register |
| q_o | output | 8 | Single-ended result byte |
| rail_err_o | output | 1 | Registered flag for a protected bit with equal rails |

## Verification
The bench uses the default byte width of 8 and feedback mask 0xB8. At that size one full sweep of the shift register drives the S-box through all 255 nonzero inputs. Each of four seed and key pairs runs that full period, including a zero seed that must be replaced. Every S-box input therefore reaches the output under several keys, against a reference S-box that the bench builds from log and antilog tables. The rail-error flag is watched on every clock of every sweep.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

  localparam int BYTE_W = 8;
  localparam int SBOX_N = 1 << BYTE_W;

  // Dual-rail byte: t carries the value, f its complement; both 0 = precharged.
  typedef struct packed {
    logic [BYTE_W-1:0] t;
    logic [BYTE_W-1:0] f;
  } dr_byte_t;

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] aa;
    acc = 8'h00;
    aa  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ aa;
      aa = {aa[6:0], 1'b0} ^ (aa[7] ? 8'h1b : 8'h00);
    end
    return acc;
  endfunction

  // Inverse as x^254 by square and multiply; 0 maps to 0.
  function automatic logic [7:0] sbox_value(input logic [7:0] x);
    logic [7:0] r;
    logic [7:0] base;
    logic [7:0] e;
    logic [7:0] inv;
    r    = 8'h01;
    base = x;
    e    = 8'd254;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = gf_mul(r, base);
      base = gf_mul(base, base);
    end
    inv = r;
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
           {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  // Column mask: bit m set when output bit bit_idx of S(m) is 1.
  function automatic logic [SBOX_N-1:0] sbox_column(input int bit_idx);
    logic [SBOX_N-1:0] col;
    logic [7:0]        s;
    col = '0;
    for (int m = 0; m < SBOX_N; m++) begin
      s = sbox_value(8'(m));
      col[m] = s[bit_idx];
    end
    return col;
  endfunction

endpackage

// File: rtl/dpa_lfsr.sv
module dpa_lfsr #(
  parameter int                 WIDTH    = 8,
  parameter logic [WIDTH-1:0]   TAP_MASK = 8'hB8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic [WIDTH-1:0] seed_i,
  output logic [WIDTH-1:0] state_o,
  output logic             run_o
);

  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] state_q, state_d;
  logic             run_q, run_d;
  logic             state_en;

  always_comb begin
    state_d  = state_q;
    run_d    = 1'b1;
    state_en = 1'b0;
    if (!run_q) begin
      state_en = 1'b1;
      state_d  = (seed_i == '0) ? ONE : seed_i;
    end else if (step_i) begin
      state_en = 1'b1;
      state_d  = {state_q[WIDTH-2:0], ^(state_q & TAP_MASK)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      run_q   <= 1'b0;
    end else begin
      run_q <= run_d;
      if (state_en) state_q <= state_d;
    end
  end

  assign state_o = state_q;
  assign run_o   = run_q;

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (state_q != '0)); // R3

endmodule

// File: rtl/dpa_rail_split.sv
module dpa_rail_split
  import dpa_pkg::*;
(
  input  logic [BYTE_W-1:0] val_i,
  input  logic              eval_i,
  output dr_byte_t          rails_o
);

  // Precharge forces both rails low; evaluate drives value and complement.
  assign rails_o.t = val_i & {BYTE_W{eval_i}};
  assign rails_o.f = ~val_i & {BYTE_W{eval_i}};

endmodule

// File: rtl/dpa_sbox_dr.sv
module dpa_sbox_dr
  import dpa_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     eval_i,
  input  dr_byte_t in_i,
  output dr_byte_t out_o
);

  logic [SBOX_N-1:0] minterm;

  // One-hot decode from rails: AND gates only, no inversion.
  for (genvar m = 0; m < SBOX_N; m++) begin : g_dec
    localparam logic [BYTE_W-1:0] CODE = BYTE_W'(m);
    logic [BYTE_W-1:0] pick;
    for (genvar b = 0; b < BYTE_W; b++) begin : g_pick
      if (CODE[b]) begin : g_hi
        assign pick[b] = in_i.t[b];
      end else begin : g_lo
        assign pick[b] = in_i.f[b];
      end
    end
    assign minterm[m] = &pick;
  end

  // Each output rail is an OR over the minterms that set it.
  for (genvar ob = 0; ob < BYTE_W; ob++) begin : g_col
    localparam logic [SBOX_N-1:0] COL = sbox_column(ob);
    assign out_o.t[ob] = |(minterm & COL);
    assign out_o.f[ob] = |(minterm & ~COL);
  end

  AST_SBOX_PRECHARGED: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_i |-> (out_o.t == '0 && out_o.f == '0)); // R6
  AST_SBOX_ONE_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    eval_i |-> ((out_o.t ^ out_o.f) == '1)); // R7
  AST_SBOX_ONE_MINTERM: assert property (@(posedge clk) disable iff (!rst_n)
    eval_i |-> ($countones(minterm) == 1)); // R7

endmodule

// File: rtl/dpa_xor_dr.sv
module dpa_xor_dr
  import dpa_pkg::*;
(
  input  dr_byte_t a_i,
  input  dr_byte_t b_i,
  output dr_byte_t y_o
);

  // Monotonic dual-rail XOR: two AND-OR terms per rail.
  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    assign y_o.t[i] = (a_i.t[i] & b_i.f[i]) | (a_i.f[i] & b_i.t[i]);
    assign y_o.f[i] = (a_i.t[i] & b_i.t[i]) | (a_i.f[i] & b_i.f[i]);
  end

endmodule

// File: rtl/dpa_sbox_path.sv
module dpa_sbox_path
  import dpa_pkg::*;
#(
  parameter logic [BYTE_W-1:0] TAP_MASK = 8'hB8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] key_i,
  input  logic [BYTE_W-1:0] seed_i,
  output logic [BYTE_W-1:0] q_o,
  output logic              rail_err_o
);

  logic              phase_q, phase_d;   // 1 = evaluate clock
  logic              run;
  logic              eval;
  logic [BYTE_W-1:0] lfsr_val;
  dr_byte_t          lfsr_dr, key_dr, sbox_dr, mix_dr;
  dr_byte_t          ff1_q, ff1_d;
  logic [BYTE_W-1:0] q_q, q_d;
  logic              q_en;
  logic              err_q, err_d;

  assign eval = phase_q & run;

  dpa_lfsr #(.WIDTH(BYTE_W), .TAP_MASK(TAP_MASK)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_i  (eval),
    .seed_i  (seed_i),
    .state_o (lfsr_val),
    .run_o   (run)
  );

  dpa_rail_split u_split_data (.val_i(lfsr_val), .eval_i(eval), .rails_o(lfsr_dr));
  dpa_rail_split u_split_key  (.val_i(key_i),    .eval_i(eval), .rails_o(key_dr));

  dpa_sbox_dr u_sbox (
    .clk    (clk),
    .rst_n  (rst_n),
    .eval_i (eval),
    .in_i   (lfsr_dr),
    .out_o  (sbox_dr)
  );

  dpa_xor_dr u_mix (.a_i(sbox_dr), .b_i(key_dr), .y_o(mix_dr));

  // Next-state logic
  always_comb begin
    phase_d = ~phase_q;
    ff1_d   = eval ? mix_dr : '0;
    q_en    = run & ~phase_q;
    q_d     = ff1_q.t;
    err_d   = (eval && ((mix_dr.t ~^ mix_dr.f) != '0)) ||
              (q_en && ((ff1_q.t ~^ ff1_q.f) != '0));
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      ff1_q   <= '0;
      q_q     <= '0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      ff1_q   <= ff1_d;
      err_q   <= err_d;
      if (q_en) q_q <= q_d;
    end
  end

  assign q_o        = q_q;
  assign rail_err_o = err_q;

  AST_FF1_PRECHARGED: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q |-> (ff1_q.t == '0 && ff1_q.f == '0)); // R8
  AST_FF1_HELD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !phase_q && $past(eval)) |-> ((ff1_q.t ^ ff1_q.f) == '1)); // R8
  AST_Q_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_q |-> $stable(q_o)); // R5
  AST_NO_RAIL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !rail_err_o); // R9

endmodule

// File: tb/tb_dpa_sbox_path.sv
module tb_dpa_sbox_path;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] key_i = 8'h00;
  logic [7:0] seed_i = 8'h00;
  logic [7:0] q_o;
  logic       rail_err_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] exp_tab [256];
  logic [7:0] log_tab [256];

  always #10 clk = ~clk; // 50 MHz

  dpa_sbox_path dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_i      (key_i),
    .seed_i     (seed_i),
    .q_o        (q_o),
    .rail_err_o (rail_err_o)
  );

  function automatic logic [7:0] ref_sbox(input logic [7:0] x);
    logic [7:0] inv;
    logic [7:0] r;
    inv = (x == 8'h00) ? 8'h00 : exp_tab[(255 - int'(log_tab[x])) % 255];
    for (int i = 0; i < 8; i++)
      r[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
    return r ^ 8'h63;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, expv);
    end
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic sweep(input logic [7:0] s, input logic [7:0] k);
    logic [7:0] st;
    logic [7:0] want;
    @(negedge clk);
    rst_n  = 1'b0;
    seed_i = s;
    key_i  = k;
    repeat (2) @(negedge clk);
    check("R1 reset q", q_o, 8'h00);
    check("R1 reset err", {7'd0, rail_err_o}, 8'h00);
    rst_n = 1'b1;
    st = (s == 8'h00) ? 8'h01 : s;
    @(posedge clk);   // edge 1: seed load
    @(posedge clk);   // edge 2: first capture
    for (int n = 0; n < 255; n++) begin
      want = ref_sbox(st) ^ k;
      @(posedge clk); // edge 2n+3
      @(negedge clk);
      // R4 R7 R8: result through dual-rail path and true rail
      check((n == 0) ? "R2 first word" : "R3 R4 word", q_o, want);
      check("R9 rail err", {7'd0, rail_err_o}, 8'h00);
      @(posedge clk); // edge 2n+4
      @(negedge clk);
      check("R5 hold", q_o, want);
      // R6 R7: no rail fault reported
      check("R9 rail err", {7'd0, rail_err_o}, 8'h00);
      st = {st[6:0], st[7] ^ st[5] ^ st[4] ^ st[3]};
    end
  endtask

  initial begin
    logic [7:0] e;
    e = 8'h01;
    for (int i = 0; i < 255; i++) begin
      exp_tab[i] = e;
      log_tab[e] = 8'(i);
      e = e ^ ({e[6:0], 1'b0} ^ (e[7] ? 8'h1b : 8'h00));
    end
    exp_tab[255] = 8'h01;
    log_tab[0]   = 8'h00;

    sweep(8'h01, 8'h00);
    sweep(8'h00, 8'hFF);   // R2 zero seed substitution
    sweep(8'hA5, 8'h5A);
    sweep(8'h80, 8'hC3);
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      report();
      $finish;
    end
  end

endmodule